// File: doc/BRIEF.md
# Shared Level Interrupt Line Aggregator

This block gathers the level-sensitive interrupt pins of several bus devices and merges them onto a small set of shared interrupt lines. Every device has four pins. Each pin is steered to one shared line by a fixed rotation that depends on the device's slot number. For each shared line the block keeps a count of the pins that are routed to it and currently asserted. The line is driven high while that count is nonzero.

The block stores the last level it has seen on every pin. A pin changes a count only when its level differs from the stored copy, so a pin that stays high is counted once. Several pins may change in the same cycle, and every rise and every fall lands in its line's count. The counters can be read out as a snapshot and loaded back later. The snapshot carries a header that holds the configured line count, and a load whose header does not match is refused.

Top module: `irq_share_agg`

## Requirements
- R1: After reset all counts are zero, every `irq_line` bit is low, and `underflow_err` and `restore_rej` are low.
- R2: Pin p (0..3) of device d is routed to line ((p + s) mod 4) mod NUM_LINES. Here s is bits [7:3] of that device's 8-bit field `dev_fn[d*8 +: 8]`, and pin p of device d is bit d*4+p of `dev_pins`.
- R3: The count of a line equals the number of asserted pins routed to it. The line is high exactly when its count is nonzero. Counts change on the clock edge that samples the new pin levels.
- R4: A pin whose sampled level equals its stored level does not change any count. Holding pins steady leaves all counts unchanged.
- R5: When several pins rise and fall in the same cycle, each line's new count is its old count plus the rises routed to it minus the falls routed to it. No update is lost.
- R6: A cycle with `dev_attach[d]` high clears the stored levels of device d to zero and ignores its pins in that cycle. Counts are not touched, so a pin still held high is counted again on the next cycle.
- R7: When a line's falls exceed its old count plus its rises, the count stays at zero and `underflow_err` is set. `underflow_err` then stays high until reset.
- R8: `snap_counts[l*CNT_W +: CNT_W]` shows the count of line l, and `snap_nlines` shows NUM_LINES. CNT_W is clog2(4*NUM_DEV+1).
- R9: When `restore_en` is high and `restore_nlines` equals NUM_LINES, all counts take the values in `restore_counts` on that edge. Pin changes in that cycle update the stored levels but not the counts.
- R10: When `restore_en` is high and `restore_nlines` differs from NUM_LINES, the load is refused. The counts follow only pin changes, and `restore_rej` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_pins | input | NUM_DEV*4 | Interrupt pin levels, four per device |
| dev_fn | input | NUM_DEV*8 | Device/function number of each device; bits [7:3] are the slot |
| dev_attach | input | NUM_DEV | Per-device attach pulse that clears the stored pin levels |
| irq_line | output | NUM_LINES | Shared interrupt line levels |
| underflow_err | output | 1 | Sticky flag for a count underflow attempt |
| snap_nlines | output | 8 | Snapshot header: configured line count |
| snap_counts | output | NUM_LINES*CNT_W | Snapshot of all line counts |
| restore_en | input | 1 | Request to load the counts |
| restore_nlines | input | 8 | Header of the snapshot being loaded |
| restore_counts | input | NUM_LINES*CNT_W | Count values to load |
| restore_rej | output | 1 | Pulse: the last load was refused |

## Verification
The assertions check the following on every cycle:
- Counts hold still when no pin event and no load occurs.
- The underflow flag is sticky and is raised only by a pin fall.
- An accepted load lands exactly.
- A refused load produces the reject pulse and nothing else does.

The routing rotation, the exact counts under mixed simultaneous rises and falls, and the re-counting of a held pin after attach can only be shown by the bench's scenarios. The same holds for the discarding of pin deltas during a load. The bench compares each of these against counts it derives from its own model of the pins.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;
  localparam int PINS_PER_DEV = 4;

  // Line reached by one pin of one device: rotate by slot, then fold.
  function automatic int route_line(input int pin, input logic [7:0] devfn, input int nlines);
    int slot;
    slot = int'(devfn[7:3]);
    return ((pin + slot) % PINS_PER_DEV) % nlines;
  endfunction

  // Next count and underflow indication for one line.
  function automatic logic [16:0] next_count(input logic [15:0] cur, input logic [15:0] inc,
                                             input logic [15:0] dec);
    logic [16:0] up;
    up = {1'b0, cur} + {1'b0, inc};
    if (up < {1'b0, dec}) return {1'b1, 16'd0};
    return {1'b0, 16'(up - {1'b0, dec})};
  endfunction
endpackage

// File: rtl/irq_pin_tracker.sv
`timescale 1ns/1ps
module irq_pin_tracker #(
  parameter int NUM_DEV = 4,
  localparam int NPINS = NUM_DEV * irq_agg_pkg::PINS_PER_DEV
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [NUM_DEV-1:0] attach,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  localparam int PPD = irq_agg_pkg::PINS_PER_DEV;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [PPD-1:0] seen;
    logic [PPD-1:0] now_lvl;
    assign now_lvl = pins[d*PPD +: PPD];
    assign rise[d*PPD +: PPD] = attach[d] ? '0 : (now_lvl & ~seen);
    assign fall[d*PPD +: PPD] = attach[d] ? '0 : (~now_lvl & seen);

    always_ff @(posedge clk) begin
      if (!rst_n)         seen <= '0;
      else if (attach[d]) seen <= '0;
      else                seen <= now_lvl;
    end
  end
endmodule

// File: rtl/irq_line_counter.sv
`timescale 1ns/1ps
module irq_line_counter #(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  parameter int LINE_ID   = 0,
  parameter int CNT_W     = 5,
  localparam int NPINS = NUM_DEV * irq_agg_pkg::PINS_PER_DEV
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   rise,
  input  logic [NPINS-1:0]   fall,
  input  logic [NUM_DEV*8-1:0] devfn,
  input  logic               load,
  input  logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   count,
  output logic               under_evt
);
  localparam int PPD = irq_agg_pkg::PINS_PER_DEV;

  logic [15:0] n_inc, n_dec;
  logic [16:0] nxt;

  always_comb begin
    n_inc = '0;
    n_dec = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PPD; p++) begin
        if (irq_agg_pkg::route_line(p, devfn[d*8 +: 8], NUM_LINES) == LINE_ID) begin
          if (rise[d*PPD+p]) n_inc = n_inc + 16'd1;
          if (fall[d*PPD+p]) n_dec = n_dec + 16'd1;
        end
      end
    end
    nxt = irq_agg_pkg::next_count(16'(count), n_inc, n_dec);
  end

  assign under_evt = !load && nxt[16];

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else           count <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/irq_share_agg.sv
`timescale 1ns/1ps
module irq_share_agg #(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  localparam int CNT_W = $clog2(NUM_DEV * irq_agg_pkg::PINS_PER_DEV + 1),
  localparam int NPINS = NUM_DEV * irq_agg_pkg::PINS_PER_DEV
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPINS-1:0]           dev_pins,
  input  logic [NUM_DEV*8-1:0]       dev_fn,
  input  logic [NUM_DEV-1:0]         dev_attach,
  output logic [NUM_LINES-1:0]       irq_line,
  output logic                       underflow_err,
  output logic [7:0]                 snap_nlines,
  output logic [NUM_LINES*CNT_W-1:0] snap_counts,
  input  logic                       restore_en,
  input  logic [7:0]                 restore_nlines,
  input  logic [NUM_LINES*CNT_W-1:0] restore_counts,
  output logic                       restore_rej
);
  logic [NPINS-1:0]     rise, fall;
  logic [NUM_LINES-1:0] under_vec;
  logic                 restore_acc;
  logic                 ev_any;
  logic                 under_any;

  assign restore_acc = restore_en && (restore_nlines == 8'(NUM_LINES));
  assign ev_any      = |rise || |fall;
  assign under_any   = |under_vec;
  assign snap_nlines = 8'(NUM_LINES);

  irq_pin_tracker #(.NUM_DEV(NUM_DEV)) u_track (
    .clk(clk), .rst_n(rst_n), .pins(dev_pins), .attach(dev_attach),
    .rise(rise), .fall(fall)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [CNT_W-1:0] cnt;
    irq_line_counter #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES), .LINE_ID(l), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .devfn(dev_fn),
      .load(restore_acc), .load_val(restore_counts[l*CNT_W +: CNT_W]),
      .count(cnt), .under_evt(under_vec[l])
    );
    assign snap_counts[l*CNT_W +: CNT_W] = cnt;
    assign irq_line[l] = |cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      underflow_err <= 1'b0;
      restore_rej   <= 1'b0;
    end else begin
      if (under_any) underflow_err <= 1'b1;
      restore_rej <= restore_en && !restore_acc;
    end
  end
endmodule

// File: rtl/irq_share_agg_chk.sv
`timescale 1ns/1ps
module irq_share_agg_chk #(
  parameter int NUM_DEV   = 4,
  parameter int NUM_LINES = 4,
  localparam int CNT_W = $clog2(NUM_DEV * irq_agg_pkg::PINS_PER_DEV + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ev_any,
  input logic                       underflow_err,
  input logic [NUM_LINES*CNT_W-1:0] snap_counts,
  input logic                       restore_en,
  input logic [7:0]                 restore_nlines,
  input logic [NUM_LINES*CNT_W-1:0] restore_counts,
  input logic                       restore_rej
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_any && !restore_en) |=> $stable(snap_counts));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err);

  assert_underflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underflow_err) |-> $past(ev_any));

  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && restore_nlines == 8'(NUM_LINES)) |=> snap_counts == $past(restore_counts));

  assert_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_en && restore_nlines != 8'(NUM_LINES)) |=> restore_rej);

  assert_reject_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restore_rej |-> $past(restore_en));
endmodule

bind irq_share_agg irq_share_agg_chk #(.NUM_DEV(NUM_DEV), .NUM_LINES(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_any(ev_any), .underflow_err(underflow_err),
  .snap_counts(snap_counts), .restore_en(restore_en), .restore_nlines(restore_nlines),
  .restore_counts(restore_counts), .restore_rej(restore_rej)
);

// File: tb/test_irq_share_agg.sv
`timescale 1ns/1ps
module test_irq_share_agg;
  localparam int ND = 4;
  localparam int NL = 4;
  localparam int CW = $clog2(ND*4+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ND*4-1:0] dev_pins = '0;
  logic [ND*8-1:0] dev_fn = {8'h38, 8'h10, 8'h08, 8'h00};
  logic [ND-1:0]   dev_attach = '0;
  logic [NL-1:0]   irq_line;
  logic            underflow_err;
  logic [7:0]      snap_nlines;
  logic [NL*CW-1:0] snap_counts;
  logic            restore_en = 1'b0;
  logic [7:0]      restore_nlines = '0;
  logic [NL*CW-1:0] restore_counts = '0;
  logic            restore_rej;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  irq_share_agg #(.NUM_DEV(ND), .NUM_LINES(NL)) i_irq_share_agg (
    .clk(clk), .rst_n(rst_n), .dev_pins(dev_pins), .dev_fn(dev_fn), .dev_attach(dev_attach),
    .irq_line(irq_line), .underflow_err(underflow_err), .snap_nlines(snap_nlines),
    .snap_counts(snap_counts), .restore_en(restore_en), .restore_nlines(restore_nlines),
    .restore_counts(restore_counts), .restore_rej(restore_rej)
  );

  localparam logic [15:0] VEC [8] = '{16'h0001, 16'h0011, 16'h0111, 16'h8111,
                                      16'hF0F0, 16'hFFFF, 16'h1248, 16'h0000};

  // Bench view of routing: slot from devfn >> 3, rotated pin masked to 2 bits.
  function automatic int model_cnt(input logic [15:0] pins, input int line);
    int c = 0;
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 4; p++)
        if (pins[d*4+p] && ((((p + (int'(dev_fn[d*8 +: 8]) >> 3)) & 3) % NL) == line)) c++;
    return c;
  endfunction

  function automatic int cnt_of(input int line);
    return int'(snap_counts[line*CW +: CW]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    // R1 reset state, R8 header
    for (int l = 0; l < NL; l++) check("R1 count", cnt_of(l), 0);
    check("R1 lines", int'(irq_line), 0);
    check("R1 underflow", int'(underflow_err), 0);
    check("R1 reject", int'(restore_rej), 0);
    check("R8 nlines", int'(snap_nlines), NL);

    // R2 R3 R5: table walk, expected counts from the bench model
    for (int v = 0; v < 8; v++) begin
      int lines_exp;
      dev_pins = VEC[v];
      step();
      lines_exp = 0;
      for (int l = 0; l < NL; l++) begin
        check("R2/R5 count", cnt_of(l), model_cnt(VEC[v], l));
        if (model_cnt(VEC[v], l) != 0) lines_exp |= (1 << l);
      end
      check("R3 lines", int'(irq_line), lines_exp);
    end

    // R4: steady pins make no change
    dev_pins = 16'h00F3;
    step();
    repeat (3) step();
    for (int l = 0; l < NL; l++) check("R4 steady", cnt_of(l), model_cnt(16'h00F3, l));
    dev_pins = '0;
    step();

    // R6: attach with pin held high re-counts it next cycle
    dev_pins = 16'h0001;
    step();
    check("R6 before", cnt_of(0), 1);
    dev_attach = 4'b0001;
    step();
    check("R6 attach cycle", cnt_of(0), 1);
    dev_attach = '0;
    step();
    check("R6 recount", cnt_of(0), 2);
    dev_pins = '0;
    step();
    check("R6 after fall", cnt_of(0), 1);

    // R10: mismatched header refused
    restore_en = 1'b1;
    restore_nlines = 8'(NL - 1);
    restore_counts = {NL{CW'(5)}};
    step();
    restore_en = 1'b0;
    check("R10 count kept", cnt_of(0), 1);
    check("R10 other kept", cnt_of(2), 0);
    check("R10 reject pulse", int'(restore_rej), 1);
    step();
    check("R10 reject drops", int'(restore_rej), 0);

    // R9: accepted load
    restore_en = 1'b1;
    restore_nlines = 8'(NL);
    restore_counts = {CW'(4), CW'(3), CW'(2), CW'(0)};
    step();
    restore_en = 1'b0;
    check("R9 line0", cnt_of(0), 0);
    check("R9 line1", cnt_of(1), 2);
    check("R9 line3", cnt_of(3), 4);
    check("R9 lines", int'(irq_line), 4'b1110);

    // R9: pin change during load does not reach counts
    dev_pins = 16'h0010;
    restore_en = 1'b1;
    restore_counts = '0;
    step();
    restore_en = 1'b0;
    check("R9 delta dropped", cnt_of(1), 0);
    step();
    check("R9 no late count", cnt_of(1), 0);

    // R7: fall with zero count clamps and sets sticky flag
    dev_pins = '0;
    step();
    check("R7 clamp", cnt_of(1), 0);
    check("R7 flag", int'(underflow_err), 1);
    repeat (3) step();
    check("R7 sticky", int'(underflow_err), 1);

    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule